// File: doc/BRIEF.md
# ECC Error Event Counter Bank

This block sits beside a memory ECC checker and keeps the error statistics a memory controller reports. The checker presents two event streams, one for corrected errors and one for uncorrected errors. Each event carries the channel, the DIMM slot within that channel, the chip-select row, the page, the offset within the page, the syndrome, and a flag that marks an event with no location information. The block counts events per class for the whole controller. It also counts them per row and channel, and per slot position shared across channels. It keeps no-info counts, keeps a record of the latest error, and measures seconds since the counters were last cleared.

A small register port with valid/ready handshake gives access to all counters, the record and a control register. The control register arms an interrupt and a halt request on uncorrected errors. A write to the clear register zeroes every counter and restarts the seconds count.

Top module: `ecc_err_bank`

## Requirements
- R1: Every accepted CE event adds one to the CE total (address 0x02), and every UE event adds one to the UE total (0x03). This holds whether the event has location information or not, and also when a CE and a UE arrive in the same cycle.
- R2: A located event adds one to the row counter selected by its type, channel and row. The counter sits at address 0x40 + idx, where idx bit 3 is the type (0 = CE, 1 = UE), bit 2 is the channel and bits 1:0 are the row.
- R3: A located event on slot n (0..2) of any channel adds one to the shared slot counter at address 0x10 + n, for CE and UE alike. Two events on the same slot in one cycle add two. A slot value of 3 adds nothing.
- R4: An event whose no-info flag is set adds one to the CE no-info counter (0x04) or the UE no-info counter (0x05). It leaves every row and slot counter unchanged.
- R5: Every counter stops at its all-ones value instead of wrapping.
- R6: Any write to address 0x01 clears all counters, the seconds count, its prescaler and the interrupt. Events that arrive in the same cycle are not counted.
- R7: The seconds counter (0x06) advances by one every PRESCALE clock cycles, counted from reset or from the last clear.
- R8: The record holds the latest event. When a CE and a UE arrive together, the UE is recorded. The word at 0x08 holds bit 0 valid, bit 1 UE, bit 2 no-info, bit 3 channel, bits 5:4 row and bits 7:6 slot. The page is at 0x09, the offset at 0x0A and the syndrome at 0x0B.
- R9: With control bit 1 set, a UE event raises halt_req in the next cycle. halt_req then stays high until rst_n is asserted.
- R10: With control bit 0 set, a UE event raises irq in the next cycle. irq stays high until a clear write (R6).
- R11: reg_ready is always high. An accepted read returns rd_valid with rd_data in the next cycle, showing the state before that edge. The control register (0x00) reads back its two bits, and unmapped addresses read as zero.
- R12: After reset every counter, the record, the control bits, irq and halt_req are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_valid | input | 1 | Corrected-error event present |
| ce_noinfo | input | 1 | CE event lacks location |
| ce_chan | input | CH_W | CE channel |
| ce_slot | input | SLOT_W | CE slot within channel |
| ce_row | input | ROW_W | CE chip-select row |
| ce_page | input | PAGE_W | CE page |
| ce_offset | input | OFF_W | CE offset in page |
| ce_synd | input | SYN_W | CE syndrome |
| ue_valid | input | 1 | Uncorrected-error event present |
| ue_noinfo | input | 1 | UE event lacks location |
| ue_chan | input | CH_W | UE channel |
| ue_slot | input | SLOT_W | UE slot within channel |
| ue_row | input | ROW_W | UE chip-select row |
| ue_page | input | PAGE_W | UE page |
| ue_offset | input | OFF_W | UE offset in page |
| ue_synd | input | SYN_W | UE syndrome |
| reg_valid | input | 1 | Register access request |
| reg_ready | output | 1 | Request accepted (always high) |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data present |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Sticky UE interrupt |
| halt_req | output | 1 | Sticky halt request on UE |

## Verification
Every counter, the record, irq and halt_req take their new value at the clock edge that samples the event, so they are visible one cycle later. A read that is accepted at an edge returns, one cycle later, the state from before that edge. The bench drives inputs on the falling edge and updates its behavioural model at each rising edge. In that same step it computes the expected read data from the model's state before the update. On the next falling edge it compares rd_valid, rd_data, irq and halt_req against the model, so every result is checked in exactly the cycle it is due.

// File: rtl/ecc_bank_pkg.sv
package ecc_bank_pkg;
  localparam logic [7:0] A_CTRL   = 8'h00;
  localparam logic [7:0] A_CLEAR  = 8'h01;
  localparam logic [7:0] A_CE_TOT = 8'h02;
  localparam logic [7:0] A_UE_TOT = 8'h03;
  localparam logic [7:0] A_CE_NI  = 8'h04;
  localparam logic [7:0] A_UE_NI  = 8'h05;
  localparam logic [7:0] A_SECS   = 8'h06;
  localparam logic [7:0] A_REC    = 8'h08;
  localparam logic [7:0] A_PAGE   = 8'h09;
  localparam logic [7:0] A_OFF    = 8'h0A;
  localparam logic [7:0] A_SYN    = 8'h0B;
  localparam logic [7:0] A_SLOT   = 8'h10;
  localparam logic [7:0] A_ROW    = 8'h40;
endpackage

// File: rtl/ecc_sat_ctr.sv
module ecc_sat_ctr #(
  parameter int W     = 16,
  parameter int INC_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     q
);
  localparam logic [W:0] MAXV = {1'b0, {W{1'b1}}};

  logic [W:0]   sum;
  logic [W-1:0] q_nx;
  logic         en;

  always_comb begin
    sum = {1'b0, q} + (W+1)'(inc);
    en  = clr || (inc != '0);
    if (clr)             q_nx = '0;
    else if (sum > MAXV) q_nx = {W{1'b1}};
    else                 q_nx = sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= q_nx;
  end

  // R5
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && q == {W{1'b1}}) |=> q == {W{1'b1}});
  // R5
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> q >= $past(q));
endmodule

// File: rtl/ecc_sec_timer.sv
module ecc_sec_timer #(
  parameter int PRESCALE = 100_000_000,
  parameter int SEC_W    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [SEC_W-1:0] secs
);
  localparam int             PRE_W    = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] pre_q, pre_nx;
  logic [SEC_W-1:0] sec_nx;
  logic             tick;

  always_comb begin
    tick   = (pre_q == PRE_LAST);
    pre_nx = tick ? '0 : pre_q + 1'b1;
    sec_nx = secs;
    if (tick && secs != {SEC_W{1'b1}}) sec_nx = secs + 1'b1;
    if (clr) begin
      pre_nx = '0;
      sec_nx = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      secs  <= '0;
    end else begin
      pre_q <= pre_nx;
      secs  <= sec_nx;
    end
  end

  // R7
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (secs == $past(secs) || secs == $past(secs) + 1'b1));
endmodule

// File: rtl/ecc_err_bank.sv
module ecc_err_bank
  import ecc_bank_pkg::*;
#(
  parameter int NCHAN    = 2,
  parameter int NROW     = 4,
  parameter int NSLOT    = 3,
  parameter int SLOT_W   = 2,
  parameter int PAGE_W   = 20,
  parameter int OFF_W    = 12,
  parameter int SYN_W    = 16,
  parameter int CNT_W    = 16,
  parameter int SEC_W    = 32,
  parameter int PRESCALE = 100_000_000,
  localparam int CH_W    = (NCHAN > 1) ? $clog2(NCHAN) : 1,
  localparam int ROW_W   = (NROW > 1) ? $clog2(NROW) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_valid,
  input  logic              ce_noinfo,
  input  logic [CH_W-1:0]   ce_chan,
  input  logic [SLOT_W-1:0] ce_slot,
  input  logic [ROW_W-1:0]  ce_row,
  input  logic [PAGE_W-1:0] ce_page,
  input  logic [OFF_W-1:0]  ce_offset,
  input  logic [SYN_W-1:0]  ce_synd,
  input  logic              ue_valid,
  input  logic              ue_noinfo,
  input  logic [CH_W-1:0]   ue_chan,
  input  logic [SLOT_W-1:0] ue_slot,
  input  logic [ROW_W-1:0]  ue_row,
  input  logic [PAGE_W-1:0] ue_page,
  input  logic [OFF_W-1:0]  ue_offset,
  input  logic [SYN_W-1:0]  ue_synd,
  input  logic              reg_valid,
  output logic              reg_ready,
  input  logic              reg_write,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              irq,
  output logic              halt_req
);
  localparam int IDX_SH = CH_W + ROW_W;

  logic clr, ctrl_wr, rd_acc, ce_loc, ue_loc;
  logic irq_en_q, halt_en_q;
  logic irq_nx, halt_nx;
  logic [CNT_W-1:0] ce_tot_q, ue_tot_q, ce_ni_q, ue_ni_q;
  logic [CNT_W-1:0] row_q  [2][NCHAN][NROW];
  logic [CNT_W-1:0] slot_q [NSLOT];
  logic [SEC_W-1:0] secs;
  logic [31:0]      rd_nx;

  logic              rec_vld_q, rec_ue_q, rec_ni_q;
  logic [CH_W-1:0]   rec_chan_q;
  logic [ROW_W-1:0]  rec_row_q;
  logic [SLOT_W-1:0] rec_slot_q;
  logic [PAGE_W-1:0] rec_page_q;
  logic [OFF_W-1:0]  rec_off_q;
  logic [SYN_W-1:0]  rec_syn_q;

  assign reg_ready = 1'b1;
  assign clr     = reg_valid && reg_write && (reg_addr == A_CLEAR);
  assign ctrl_wr = reg_valid && reg_write && (reg_addr == A_CTRL);
  assign rd_acc  = reg_valid && !reg_write;
  assign ce_loc  = ce_valid && !ce_noinfo;
  assign ue_loc  = ue_valid && !ue_noinfo;

  ecc_sat_ctr #(.W(CNT_W), .INC_W(1)) u_ce_tot (.clk(clk), .rst_n(rst_n), .clr(clr), .inc(ce_valid), .q(ce_tot_q));
  ecc_sat_ctr #(.W(CNT_W), .INC_W(1)) u_ue_tot (.clk(clk), .rst_n(rst_n), .clr(clr), .inc(ue_valid), .q(ue_tot_q));
  ecc_sat_ctr #(.W(CNT_W), .INC_W(1)) u_ce_ni  (.clk(clk), .rst_n(rst_n), .clr(clr), .inc(ce_valid && ce_noinfo), .q(ce_ni_q));
  ecc_sat_ctr #(.W(CNT_W), .INC_W(1)) u_ue_ni  (.clk(clk), .rst_n(rst_n), .clr(clr), .inc(ue_valid && ue_noinfo), .q(ue_ni_q));

  for (genvar t = 0; t < 2; t++) begin : g_type
    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
      for (genvar r = 0; r < NROW; r++) begin : g_row
        logic hit;
        if (t == 0) begin : g_ce
          assign hit = ce_loc && ce_chan == CH_W'(c) && ce_row == ROW_W'(r);
        end else begin : g_ue
          assign hit = ue_loc && ue_chan == CH_W'(c) && ue_row == ROW_W'(r);
        end
        ecc_sat_ctr #(.W(CNT_W), .INC_W(1)) u_ctr (
          .clk(clk), .rst_n(rst_n), .clr(clr), .inc(hit), .q(row_q[t][c][r]));
      end
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [1:0] amt;
    assign amt = 2'(ce_loc && ce_slot == SLOT_W'(s)) + 2'(ue_loc && ue_slot == SLOT_W'(s));
    ecc_sat_ctr #(.W(CNT_W), .INC_W(2)) u_ctr (
      .clk(clk), .rst_n(rst_n), .clr(clr), .inc(amt), .q(slot_q[s]));
  end

  ecc_sec_timer #(.PRESCALE(PRESCALE), .SEC_W(SEC_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(clr), .secs(secs));

  // control, interrupt and halt
  always_comb begin
    irq_nx  = clr ? 1'b0 : (irq || (ue_valid && irq_en_q));
    halt_nx = halt_req || (ue_valid && halt_en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q  <= 1'b0;
      halt_en_q <= 1'b0;
      irq       <= 1'b0;
      halt_req  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        irq_en_q  <= reg_wdata[0];
        halt_en_q <= reg_wdata[1];
      end
      irq      <= irq_nx;
      halt_req <= halt_nx;
    end
  end

  // latest-error record, UE takes precedence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_vld_q <= 1'b0; rec_ue_q <= 1'b0; rec_ni_q <= 1'b0;
      rec_chan_q <= '0; rec_row_q <= '0; rec_slot_q <= '0;
      rec_page_q <= '0; rec_off_q <= '0; rec_syn_q <= '0;
    end else if (ue_valid) begin
      rec_vld_q <= 1'b1; rec_ue_q <= 1'b1; rec_ni_q <= ue_noinfo;
      rec_chan_q <= ue_chan; rec_row_q <= ue_row; rec_slot_q <= ue_slot;
      rec_page_q <= ue_page; rec_off_q <= ue_offset; rec_syn_q <= ue_synd;
    end else if (ce_valid) begin
      rec_vld_q <= 1'b1; rec_ue_q <= 1'b0; rec_ni_q <= ce_noinfo;
      rec_chan_q <= ce_chan; rec_row_q <= ce_row; rec_slot_q <= ce_slot;
      rec_page_q <= ce_page; rec_off_q <= ce_offset; rec_syn_q <= ce_synd;
    end
  end

  // read mux
  always_comb begin
    rd_nx = '0;
    case (reg_addr)
      A_CTRL:   rd_nx = 32'({halt_en_q, irq_en_q});
      A_CE_TOT: rd_nx = 32'(ce_tot_q);
      A_UE_TOT: rd_nx = 32'(ue_tot_q);
      A_CE_NI:  rd_nx = 32'(ce_ni_q);
      A_UE_NI:  rd_nx = 32'(ue_ni_q);
      A_SECS:   rd_nx = 32'(secs);
      A_REC:    rd_nx = 32'({rec_slot_q, rec_row_q, rec_chan_q, rec_ni_q, rec_ue_q, rec_vld_q});
      A_PAGE:   rd_nx = 32'(rec_page_q);
      A_OFF:    rd_nx = 32'(rec_off_q);
      A_SYN:    rd_nx = 32'(rec_syn_q);
      default: begin
        for (int s = 0; s < NSLOT; s++)
          if (reg_addr == A_SLOT + 8'(s)) rd_nx = 32'(slot_q[s]);
        for (int t = 0; t < 2; t++)
          for (int c = 0; c < NCHAN; c++)
            for (int r = 0; r < NROW; r++)
              if (reg_addr == A_ROW + 8'((t << IDX_SH) | (c << ROW_W) | r))
                rd_nx = 32'(row_q[t][c][r]);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_acc;
      if (rd_acc) rd_data <= rd_nx;
    end
  end

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> halt_req);
  // R10
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_valid && irq_en_q && !clr) |=> irq);
  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ce_tot_q == '0 && ue_tot_q == '0 && secs == '0 && !irq));
  // R11
  rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rd_valid);
  // R11
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> !rd_valid);
endmodule

// File: tb/tb_ecc_err_bank.sv
module tb_ecc_err_bank;
  localparam int CNT_W = 4;
  localparam int PRE   = 20;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_valid = 0, ce_noinfo = 0, ue_valid = 0, ue_noinfo = 0;
  logic [0:0]  ce_chan = 0, ue_chan = 0;
  logic [1:0]  ce_slot = 0, ue_slot = 0, ce_row = 0, ue_row = 0;
  logic [19:0] ce_page = 0, ue_page = 0;
  logic [11:0] ce_offset = 0, ue_offset = 0;
  logic [15:0] ce_synd = 0, ue_synd = 0;
  logic        reg_valid = 0, reg_write = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic        reg_ready, rd_valid, irq, halt_req;
  logic [31:0] rd_data;

  always #5 clk = ~clk;

  ecc_err_bank #(.CNT_W(CNT_W), .PRESCALE(PRE)) dut (
    .clk(clk), .rst_n(rst_n),
    .ce_valid(ce_valid), .ce_noinfo(ce_noinfo), .ce_chan(ce_chan), .ce_slot(ce_slot),
    .ce_row(ce_row), .ce_page(ce_page), .ce_offset(ce_offset), .ce_synd(ce_synd),
    .ue_valid(ue_valid), .ue_noinfo(ue_noinfo), .ue_chan(ue_chan), .ue_slot(ue_slot),
    .ue_row(ue_row), .ue_page(ue_page), .ue_offset(ue_offset), .ue_synd(ue_synd),
    .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .irq(irq), .halt_req(halt_req));

  int tests = 0, fails = 0;
  string phase = "R12";

  // behavioural reference model
  int m_tot[2], m_ni[2], m_row[2][2][4], m_slot[3];
  int m_secs, m_pre, m_irq_en, m_halt_en, m_irq, m_halt;
  int r_vld, r_ue, r_ni, r_ch, r_row, r_slot, r_page, r_off, r_syn;
  int m_rdv, m_rdd, m_rda;

  function automatic int sat(input int v);
    return (v > MAXC) ? MAXC : v;
  endfunction

  function automatic int mread(input int a);
    if (a == 0) return m_irq_en | (m_halt_en << 1);
    if (a == 2) return m_tot[0];
    if (a == 3) return m_tot[1];
    if (a == 4) return m_ni[0];
    if (a == 5) return m_ni[1];
    if (a == 6) return m_secs;
    if (a == 8) return r_vld | (r_ue << 1) | (r_ni << 2) | (r_ch << 3) | (r_row << 4) | (r_slot << 6);
    if (a == 9) return r_page;
    if (a == 10) return r_off;
    if (a == 11) return r_syn;
    if (a >= 16 && a <= 18) return m_slot[a-16];
    if (a >= 64 && a <= 79) return m_row[(a>>3)&1][(a>>2)&1][a&3];
    return 0;
  endfunction

  function automatic string tag_of(input int a);
    if (a == 2 || a == 3) return "R1";
    if (a == 4 || a == 5) return "R4";
    if (a == 6) return "R7";
    if (a >= 8 && a <= 11) return "R8";
    if (a >= 16 && a <= 18) return "R3";
    if (a >= 64 && a <= 79) return "R2";
    return "R11";
  endfunction

  task automatic m_event(input int ue, input int ni, input int ch, input int sl, input int rw);
    m_tot[ue] = sat(m_tot[ue] + 1);
    if (ni != 0) m_ni[ue] = sat(m_ni[ue] + 1);
    else begin
      m_row[ue][ch][rw] = sat(m_row[ue][ch][rw] + 1);
      if (sl < 3) m_slot[sl] = sat(m_slot[sl] + 1);
    end
  endtask

  task automatic m_reset();
    foreach (m_tot[i]) begin m_tot[i] = 0; m_ni[i] = 0; end
    foreach (m_row[i,j,k]) m_row[i][j][k] = 0;
    foreach (m_slot[i]) m_slot[i] = 0;
    m_secs = 0; m_pre = 0; m_irq = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reset();
      m_irq_en = 0; m_halt_en = 0; m_halt = 0; m_rdv = 0; m_rdd = 0; m_rda = 0;
      r_vld = 0; r_ue = 0; r_ni = 0; r_ch = 0; r_row = 0; r_slot = 0;
      r_page = 0; r_off = 0; r_syn = 0;
    end else begin
      m_rdv = (reg_valid && !reg_write) ? 1 : 0;
      if (m_rdv != 0) begin m_rdd = mread(int'(reg_addr)); m_rda = int'(reg_addr); end
      if (ue_valid && m_halt_en != 0) m_halt = 1;
      if (ue_valid && m_irq_en != 0) m_irq = 1;
      if (ue_valid) begin
        r_vld = 1; r_ue = 1; r_ni = ue_noinfo; r_ch = ue_chan; r_row = ue_row; r_slot = ue_slot;
        r_page = ue_page; r_off = ue_offset; r_syn = ue_synd;
      end else if (ce_valid) begin
        r_vld = 1; r_ue = 0; r_ni = ce_noinfo; r_ch = ce_chan; r_row = ce_row; r_slot = ce_slot;
        r_page = ce_page; r_off = ce_offset; r_syn = ce_synd;
      end
      if (reg_valid && reg_write && reg_addr == 8'h00) begin
        m_irq_en = reg_wdata[0]; m_halt_en = reg_wdata[1];
      end
      if (reg_valid && reg_write && reg_addr == 8'h01) m_reset();
      else begin
        if (ce_valid) m_event(0, ce_noinfo, ce_chan, ce_slot, ce_row);
        if (ue_valid) m_event(1, ue_noinfo, ue_chan, ue_slot, ue_row);
        if (m_pre == PRE - 1) begin m_pre = 0; m_secs = m_secs + 1; end
        else m_pre = m_pre + 1;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s]: actual %0d expected %0d", tag, phase, act, exp);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R10", int'(irq), m_irq);
      check("R9", int'(halt_req), m_halt);
      check("R11", int'(rd_valid), m_rdv);
      check("R11", int'(reg_ready), 1);
      if (m_rdv != 0 && rd_valid) check(tag_of(m_rda), int'(rd_data), m_rdd);
    end
  end

  task automatic tick();
    @(negedge clk);
    ce_valid = 0; ue_valid = 0; reg_valid = 0; reg_write = 0;
  endtask
  task automatic set_ce(input bit ni, input int ch, input int sl, input int rw, input int pg);
    ce_valid = 1; ce_noinfo = ni; ce_chan = 1'(ch); ce_slot = 2'(sl); ce_row = 2'(rw);
    ce_page = 20'(pg); ce_offset = 12'(pg * 3); ce_synd = 16'(pg + 7);
  endtask
  task automatic set_ue(input bit ni, input int ch, input int sl, input int rw, input int pg);
    ue_valid = 1; ue_noinfo = ni; ue_chan = 1'(ch); ue_slot = 2'(sl); ue_row = 2'(rw);
    ue_page = 20'(pg); ue_offset = 12'(pg * 5); ue_synd = 16'(pg + 11);
  endtask
  task automatic wr(input int a, input int d);
    reg_valid = 1; reg_write = 1; reg_addr = 8'(a); reg_wdata = 32'(d); tick();
  endtask
  task automatic rd(input int a);
    reg_valid = 1; reg_write = 0; reg_addr = 8'(a); tick();
  endtask
  task automatic read_all();
    for (int a = 0; a < 12; a++) rd(a);
    for (int a = 16; a < 19; a++) rd(a);
    for (int a = 64; a < 80; a++) rd(a);
    rd(8'h30);
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    phase = "R12"; read_all();
    phase = "R1";  wr(0, 1); rd(0);
    set_ce(0, 0, 0, 1, 100); tick();
    set_ce(0, 1, 2, 3, 101); tick();
    set_ue(0, 1, 0, 2, 102); tick();
    set_ce(0, 0, 1, 0, 103); set_ue(0, 1, 1, 0, 104); tick();
    phase = "R3";  set_ce(0, 0, 3, 2, 105); tick();
    set_ce(0, 1, 2, 1, 106); set_ue(0, 0, 2, 1, 107); tick();
    phase = "R4";  set_ce(1, 0, 1, 1, 108); tick();
    set_ue(1, 1, 2, 3, 109); tick();
    phase = "R8";  rd(8); rd(9); rd(10); rd(11);
    set_ce(0, 1, 1, 2, 110); tick(); rd(8); rd(9); rd(11);
    read_all();
    phase = "R5";
    for (int i = 0; i < 20; i++) begin set_ce(0, 0, 0, 0, 200 + i); tick(); end
    read_all();
    phase = "R7";  repeat (3 * PRE + 5) tick(); rd(6);
    phase = "R6";  set_ue(0, 0, 1, 1, 300); wr(1, 0); read_all();
    phase = "R7";  repeat (PRE - 1) tick(); rd(6); rd(6); tick(); rd(6);
    phase = "R9";  wr(0, 2); rd(0); set_ue(0, 0, 0, 3, 400); tick(); tick();
    wr(1, 0); tick(); tick();
    phase = "R10"; wr(0, 3); set_ue(1, 0, 0, 0, 401); tick(); tick(); wr(1, 0); tick();
    phase = "R11"; rd(8'h07); rd(8'hFF); read_all();
    repeat (4) tick();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule